// File: doc/BRIEF.md
# SMBus Alert Signalling and Alert-Response Responder

This block lets a slave device signal an interrupt over the shared, wired-OR SMBus alert line and handles the host's alert-response read. When the alert feature is switched on and a fault event arrives, the block drives the open-drain alert line low and sets a sticky "this device raised the alert" flag. The host then issues a one-byte read to the alert response address. The block acknowledges that address only while it is actually alerting. It returns its own 7-bit address as the data byte and releases the line once the byte has gone out. The sticky flag stays set until host software writes a one to its clear bit, and such a clear is honoured only after the alert-response read has been serviced.

The block sits beside a byte-level bus engine. That engine strobes every received slave address together with its direction bit, requests a read byte, reports when the byte has been shifted out, and strobes register writes with an 8-bit register index and data. When the pin is assigned to the alert function but the feature is switched off, the pin becomes a plain fault output that follows the fault input. Bit-level bus timing and fault detection are done elsewhere.

Top module: `smb_alert_resp`

States of the controller: `ST_IDLE` (nothing pending), `ST_RAISED` (alert driven, waiting for the alert-response address), `ST_ACKED` (address acknowledged, waiting for the read request), `ST_SENDING` (own address loaded, waiting for the byte to finish) and `ST_SERVED` (line released, sticky flag still set). Transitions:
- `ST_IDLE`→`ST_RAISED` on a fault rising edge while enabled.
- `ST_RAISED`→`ST_ACKED` on a read-direction strobe of the alert response address.
- `ST_ACKED`→`ST_SENDING` on a read request.
- `ST_ACKED`/`ST_SENDING`→`ST_RAISED` when a new address strobe aborts the transfer.
- `ST_SENDING`→`ST_SERVED` on byte done.
- `ST_SERVED`→`ST_IDLE` on a valid clear write.

## Requirements
- R1: After reset, alert_pull, trig_flag and addr_ack are 0, rd_data is 0x00, and the alert feature is disabled.
- R2: A write to register index 0x40 sets the alert enable to data bit 4, so 0x10 enables and 0x00 disables.
- R3: With the alert feature enabled, pin_is_alert at 1 and the controller idle, a rising edge on fault_in sets alert_pull and trig_flag from the next clock edge onward.
- R4: A strobe of address 0x09 with addr_rnw at 1 while alerting gives addr_ack at 1 for exactly the one cycle after the strobe.
- R5: A read request after the acknowledge loads rd_data with own_addr in bits 7:1 and 0 in bit 0, visible in the next cycle.
- R6: Byte done after the own-address byte releases alert_pull while trig_flag stays at 1.
- R7: A clear write (index 0x1C, data bit 7 at 1) that arrives before the alert-response byte has completed leaves trig_flag and alert_pull unchanged.
- R8: After the alert-response read, a write to index 0x1C with data bit 7 at 1 clears trig_flag, and a write with bit 7 at 0 does not.
- R9: A new fault rising edge while trig_flag is still set does not reassert alert_pull, and after the clear a later rising edge does.
- R10: Address 0x09 is not acknowledged while the device is not alerting, and neither a write-direction strobe of 0x09 nor a read strobe of any other address is acknowledged.
- R11: With pin_is_alert at 1 and the feature disabled, alert_pull follows fault_in combinationally, and with pin_is_alert at 0, alert_pull stays 0.
- R12: A fault edge while the feature is disabled does not set trig_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 7 | This device's 7-bit bus address |
| pin_is_alert | input | 1 | Pin is assigned to the alert function |
| fault_in | input | 1 | Fault level from the fault logic |
| addr_stb | input | 1 | Address byte received (one-cycle strobe) |
| addr | input | 7 | Received 7-bit slave address |
| addr_rnw | input | 1 | Direction bit of the received address, 1 = read |
| addr_ack | output | 1 | Acknowledge the strobed address |
| rd_req | input | 1 | Engine requests the read byte |
| rd_data | output | 8 | Byte to send for the read |
| tx_done | input | 1 | Read byte has been shifted out |
| wr_stb | input | 1 | Register write strobe |
| wr_reg | input | 8 | Register index of the write |
| wr_data | input | 8 | Register write data |
| alert_pull | output | 1 | 1 = drive the open-drain line low |
| trig_flag | output | 1 | Sticky flag: this device raised the alert |

## Verification
The bench aims at the clear that comes too early, both before the acknowledge and between acknowledge and byte done. A design that honoured it would drop trig_flag and leave the host unable to tell who interrupted. It strobes the response address while idle, after service, in the write direction and with a neighbouring address. A responder that acknowledged any of these would collide with other devices on the wired-OR bus. It raises a second fault while the flag is set, so a design that re-armed too early shows a reasserted line. It also switches the feature off mid-alert, where the pin has to fall back to tracking the fault level.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAISED  = 3'd1,
        ST_ACKED   = 3'd2,
        ST_SENDING = 3'd3,
        ST_SERVED  = 3'd4
    } sa_state_e;
endpackage

// File: rtl/sa_rise_det.sv
module sa_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/sa_regif.sv
module sa_regif #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  CFG_IDX  = 8'h40,
    parameter logic [7:0]  STAT_IDX = 8'h1C,
    parameter int          EN_POS   = 4,
    parameter int          CLR_POS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    output logic              alert_en,
    output logic              clr_req
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            alert_en <= 1'b0;
        else if (wr_stb && wr_reg == DATA_W'(CFG_IDX))
            alert_en <= wr_data[EN_POS];
    end

    assign clr_req = wr_stb && (wr_reg == DATA_W'(STAT_IDX)) && wr_data[CLR_POS];
endmodule

// File: rtl/sa_ara_fsm.sv
module sa_ara_fsm
    import sa_pkg::*;
#(
    parameter int              ADDR_W   = 7,
    parameter logic [6:0]      ARA_ADDR = 7'h09,
    localparam int             DATA_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alert_en,
    input  logic              fault_rise,
    input  logic              clr_req,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_rnw,
    input  logic              rd_req,
    input  logic              tx_done,
    output logic              addr_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              alerting,
    output logic              trig_flag
);
    sa_state_e state, state_nx;
    logic      ara_hit;

    assign ara_hit = addr_stb && addr_rnw && (addr == ADDR_W'(ARA_ADDR));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (alert_en && fault_rise) state_nx = ST_RAISED;
            ST_RAISED:  if (ara_hit)                state_nx = ST_ACKED;
            ST_ACKED: begin
                if (addr_stb)                       state_nx = ST_RAISED;
                else if (rd_req)                    state_nx = ST_SENDING;
            end
            ST_SENDING: begin
                if (addr_stb)                       state_nx = ST_RAISED;
                else if (tx_done)                   state_nx = ST_SERVED;
            end
            ST_SERVED:  if (clr_req)                state_nx = ST_IDLE;
            default:                                state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_ack <= 1'b0;
            rd_data  <= '0;
        end else begin
            addr_ack <= (state == ST_RAISED) && ara_hit;
            if (state == ST_ACKED && !addr_stb && rd_req)
                rd_data <= {own_addr, 1'b0};
        end
    end

    assign alerting  = (state == ST_RAISED) || (state == ST_ACKED) || (state == ST_SENDING);
    assign trig_flag = (state != ST_IDLE);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  ARA_ADDR = 7'h09,
    parameter logic [7:0]  CFG_IDX  = 8'h40,
    parameter logic [7:0]  STAT_IDX = 8'h1C,
    localparam int         DATA_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              pin_is_alert,
    input  logic              fault_in,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_rnw,
    output logic              addr_ack,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_done,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    output logic              alert_pull,
    output logic              trig_flag
);
    logic fault_rise;
    logic alert_en;
    logic clr_req;
    logic alerting;

    sa_rise_det u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (fault_in),
        .rise     (fault_rise)
    );

    sa_regif #(
        .DATA_W   (DATA_W),
        .CFG_IDX  (CFG_IDX),
        .STAT_IDX (STAT_IDX),
        .EN_POS   (4),
        .CLR_POS  (7)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data),
        .alert_en (alert_en),
        .clr_req  (clr_req)
    );

    sa_ara_fsm #(
        .ADDR_W   (ADDR_W),
        .ARA_ADDR (ARA_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .alert_en   (alert_en),
        .fault_rise (fault_rise),
        .clr_req    (clr_req),
        .own_addr   (own_addr),
        .addr_stb   (addr_stb),
        .addr       (addr),
        .addr_rnw   (addr_rnw),
        .rd_req     (rd_req),
        .tx_done    (tx_done),
        .addr_ack   (addr_ack),
        .rd_data    (rd_data),
        .alerting   (alerting),
        .trig_flag  (trig_flag)
    );

    // pin: alert function when enabled, plain fault output otherwise
    assign alert_pull = pin_is_alert & (alert_en ? alerting : fault_in);
endmodule

// File: rtl/sa_alert_chk.sv
module sa_alert_chk #(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  ARA_ADDR = 7'h09,
    parameter logic [7:0]  STAT_IDX = 8'h1C,
    localparam int         DATA_W   = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_stb,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_rnw,
    input logic              addr_ack,
    input logic              rd_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_reg,
    input logic [DATA_W-1:0] wr_data,
    input logic              alert_pull,
    input logic              trig_flag,
    input logic              fault_in,
    input logic              alert_en
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |=> !addr_ack);                                            // R4
    AST_ACK_FROM_ARA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(addr_stb && addr_rnw && addr == ADDR_W'(ARA_ADDR))); // R10
    AST_ACK_ONLY_WHEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> $past(trig_flag));                                     // R10
    AST_RDDATA_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(rd_req));                               // R5
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_flag) |-> $past(wr_stb && wr_reg == DATA_W'(STAT_IDX) && wr_data[7])); // R8
    AST_CLEAR_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_flag) |-> !$past(alert_pull && alert_en));               // R7
    AST_FLAG_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_flag) |-> $past(fault_in && alert_en));                  // R3
    AST_ENABLED_PULL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_pull && alert_en) |-> trig_flag);                            // R9
endmodule

bind smb_alert_resp sa_alert_chk #(
    .ADDR_W   (ADDR_W),
    .ARA_ADDR (ARA_ADDR),
    .STAT_IDX (STAT_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_stb   (addr_stb),
    .addr       (addr),
    .addr_rnw   (addr_rnw),
    .addr_ack   (addr_ack),
    .rd_req     (rd_req),
    .rd_data    (rd_data),
    .wr_stb     (wr_stb),
    .wr_reg     (wr_reg),
    .wr_data    (wr_data),
    .alert_pull (alert_pull),
    .trig_flag  (trig_flag),
    .fault_in   (fault_in),
    .alert_en   (alert_en)
);

// File: tb/smb_alert_resp_bench.sv
module smb_alert_resp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = 7'h35;
    logic       pin_is_alert = 1'b0;
    logic       fault_in = 1'b0;
    logic       addr_stb = 1'b0;
    logic [6:0] addr = 7'h00;
    logic       addr_rnw = 1'b0;
    logic       addr_ack;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       tx_done = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_reg = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       alert_pull;
    logic       trig_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smb_alert_resp u_smb_alert_resp (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .pin_is_alert(pin_is_alert),
        .fault_in(fault_in), .addr_stb(addr_stb), .addr(addr), .addr_rnw(addr_rnw),
        .addr_ack(addr_ack), .rd_req(rd_req), .rd_data(rd_data), .tx_done(tx_done),
        .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_data(wr_data),
        .alert_pull(alert_pull), .trig_flag(trig_flag)
    );

    // behavioural reference: phase 0 idle, 1 alerting, 2 acked, 3 sending, 4 served
    int   m_phase = 0;
    bit   m_en = 0, m_fprev = 0, m_ack = 0;
    int   m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_en = 0; m_fprev = 0; m_ack = 0; m_rd = 0;
        end else begin
            bit rise, hit, clr;
            rise = fault_in && !m_fprev;
            hit  = addr_stb && addr_rnw && addr == 7'h09;
            clr  = wr_stb && wr_reg == 8'h1C && wr_data[7];
            m_ack = 0;
            if (m_phase == 0) begin
                if (m_en && rise) m_phase = 1;
            end else if (m_phase == 1) begin
                if (hit) begin m_ack = 1; m_phase = 2; end
            end else if (m_phase == 2) begin
                if (addr_stb) m_phase = 1;
                else if (rd_req) begin m_rd = int'(own_addr) * 2; m_phase = 3; end
            end else if (m_phase == 3) begin
                if (addr_stb) m_phase = 1;
                else if (tx_done) m_phase = 4;
            end else if (clr) m_phase = 0;
            if (wr_stb && wr_reg == 8'h40) m_en = wr_data[4];
            m_fprev = fault_in;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_pull;
            exp_pull = pin_is_alert && (m_en ? (m_phase >= 1 && m_phase <= 3) : fault_in);
            chk(alert_pull == exp_pull, "R3 model alert_pull", int'(alert_pull), int'(exp_pull));
            chk(trig_flag == (m_phase != 0), "R8 model trig_flag", int'(trig_flag), int'(m_phase != 0));
            chk(addr_ack == m_ack, "R4 model addr_ack", int'(addr_ack), int'(m_ack));
            chk(int'(rd_data) == m_rd, "R5 model rd_data", int'(rd_data), m_rd);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        addr_stb = 0; rd_req = 0; tx_done = 0; wr_stb = 0;
        #1;
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] val);
        wr_stb = 1; wr_reg = idx; wr_data = val; step();
    endtask

    task automatic do_addr(input logic [6:0] a, input logic rnw);
        addr_stb = 1; addr = a; addr_rnw = rnw; step();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1; #1;
        chk(alert_pull == 0 && trig_flag == 0 && addr_ack == 0, "R1 reset outputs",
            int'({alert_pull, trig_flag, addr_ack}), 0);
        chk(rd_data == 8'h00, "R1 reset rd_data", int'(rd_data), 0);

        // fallback fault output while disabled
        pin_is_alert = 1; fault_in = 1; #1;
        chk(alert_pull == 1, "R11 fallback follows fault", int'(alert_pull), 1);
        step();
        chk(trig_flag == 0, "R12 no flag when disabled", int'(trig_flag), 0);
        fault_in = 0; #1;
        chk(alert_pull == 0, "R11 fallback release", int'(alert_pull), 0);
        pin_is_alert = 0; fault_in = 1; #1;
        chk(alert_pull == 0, "R11 pin not assigned", int'(alert_pull), 0);
        fault_in = 0; pin_is_alert = 1; step();

        do_addr(7'h09, 1'b1);
        chk(addr_ack == 0, "R10 idle ARA ignored", int'(addr_ack), 0);

        do_write(8'h40, 8'h10);
        fault_in = 1; step();
        chk(alert_pull == 1 && trig_flag == 1, "R3 alert raised", int'({alert_pull, trig_flag}), 3);
        chk(trig_flag == 1, "R2 enable took effect", int'(trig_flag), 1);

        do_write(8'h1C, 8'h80);
        chk(trig_flag == 1 && alert_pull == 1, "R7 early clear ignored", int'({alert_pull, trig_flag}), 3);

        do_addr(7'h09, 1'b0);
        chk(addr_ack == 0, "R10 write-direction ARA", int'(addr_ack), 0);
        do_addr(7'h0A, 1'b1);
        chk(addr_ack == 0, "R10 other address", int'(addr_ack), 0);

        do_addr(7'h09, 1'b1);
        chk(addr_ack == 1, "R4 ARA acknowledged", int'(addr_ack), 1);
        do_write(8'h1C, 8'h80);
        chk(addr_ack == 0, "R4 ack lasts one cycle", int'(addr_ack), 0);
        chk(trig_flag == 1, "R7 clear after ack ignored", int'(trig_flag), 1);

        rd_req = 1; step();
        chk(rd_data == 8'h6A, "R5 own address byte", int'(rd_data), 8'h6A);
        chk(alert_pull == 1, "R6 held until sent", int'(alert_pull), 1);

        tx_done = 1; step();
        chk(alert_pull == 0 && trig_flag == 1, "R6 released after send",
            int'({alert_pull, trig_flag}), 1);

        fault_in = 0; step();
        fault_in = 1; step();
        chk(alert_pull == 0, "R9 no reassert while flagged", int'(alert_pull), 0);
        do_addr(7'h09, 1'b1);
        chk(addr_ack == 0, "R10 served ARA ignored", int'(addr_ack), 0);

        do_write(8'h1C, 8'h7F);
        chk(trig_flag == 1, "R8 bit 7 zero keeps flag", int'(trig_flag), 1);
        do_write(8'h1C, 8'h80);
        chk(trig_flag == 0, "R8 clear after service", int'(trig_flag), 0);

        step();
        chk(alert_pull == 0, "R9 held level no new edge", int'(alert_pull), 0);
        fault_in = 0; step();
        fault_in = 1; step();
        chk(alert_pull == 1 && trig_flag == 1, "R9 rearmed after clear",
            int'({alert_pull, trig_flag}), 3);

        // abort of a half-done response returns to alerting
        do_addr(7'h09, 1'b1);
        do_addr(7'h20, 1'b1);
        chk(alert_pull == 1 && addr_ack == 0, "R4 abort keeps alerting",
            int'({alert_pull, addr_ack}), 2);

        do_write(8'h40, 8'h00);
        fault_in = 0; #1;
        chk(alert_pull == 0, "R2 disabled pin tracks fault low", int'(alert_pull), 0);
        fault_in = 1; #1;
        chk(alert_pull == 1, "R11 disabled pin tracks fault high", int'(alert_pull), 1);
        chk(trig_flag == 1, "R11 flag kept when disabled", int'(trig_flag), 1);
        step(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule